// File: doc/BRIEF.md
# Carry-chained add execute unit

This block executes one kind of instruction: a 32-bit addition of two register operands plus a stored carry bit. Each instruction word presented with a valid strobe is decoded. When it matches the add-with-carry encoding, the unit reads two entries of its internal 32 x 32-bit register file. It adds them together with the stored carry and writes the truncated sum back to the destination entry.

Every accepted add rewrites the carry bit. Two option bits in the instruction control the rest. The overflow bit sets the signed-overflow flag and the sticky summary-overflow flag. The record bit sets a four-bit condition field, which compares the 32-bit result against zero as a signed value and also holds a copy of the summary flag.

Because the carry-out of one add becomes the carry-in of the next, a 64-bit or wider sum can be built from a chain of 32-bit adds. A debug port can write any register and read any register, so operands can be loaded and results observed.

Top module: `cadd_unit`

## Requirements
- R1: An accepted instruction writes rA + rB + CA (modulo 2^32) to register rD. The result is readable on the debug read port after the clock edge that samples the valid strobe.
- R2: Bit 31 is the most significant bit of the instruction word. The word is accepted only when bits [31:26] = 6'b011111 and bits [9:1] = 9'd138. The fields are rD = [25:21], rA = [20:16], rB = [15:11], the overflow-enable bit = [10] and the record bit = [0]. Any other word pulses illegal_o for one cycle and leaves the registers, CA, OV, SO and the condition field unchanged.
- R3: Every accepted add loads CA with the carry-out of the three-input 32-bit sum, whatever the option bits are.
- R4: With overflow-enable = 1, OV is loaded with the signed two's-complement overflow of the sum, which clears OV when there is no overflow. With overflow-enable = 0, OV and SO keep their values.
- R5: SO becomes the OR of its old value and the new OV, so once set it stays set until reset.
- R6: With record = 1, cond_o is loaded with {LT, GT, EQ, SO}, bit 3 first. LT, GT and EQ come from a signed compare of the truncated 32-bit result against zero, and exactly one of them is set. The SO bit is the summary flag after this instruction's update.
- R7: With record = 0, cond_o keeps its value.
- R8: done_o is high for exactly one cycle after each cycle in which valid_i is high, whether or not the word is legal.
- R9: Reset clears all registers, CA, OV, SO, cond_o, done_o and illegal_o.
- R10: If a debug write and an accepted add target the same register in the same cycle, the add result is stored. Operands are read from values held before the clock edge, so a debug write in the same cycle is not seen by that add.
- R11: Chaining works: a carry from a low-word add feeds the high-word add that follows, giving the correct 64-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 32 | Instruction word |
| dbg_we_i | input | 1 | Debug register write enable |
| dbg_waddr_i | input | 5 | Debug write index |
| dbg_wdata_i | input | 32 | Debug write data |
| dbg_raddr_i | input | 5 | Debug read index |
| dbg_rdata_o | output | 32 | Debug read data (combinational) |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle illegal-encoding pulse |
| ca_o | output | 1 | Stored carry |
| ov_o | output | 1 | Overflow flag |
| so_o | output | 1 | Sticky summary-overflow flag |
| cond_o | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
A debug write and an add's writeback can land in the same cycle. The bench provokes this by writing the destination register through the debug port in the very cycle that the add is strobed, then reads the register back and expects the add's sum, not the debug data. In a second case the debug port rewrites a source register of a strobed add in the same cycle. The bench expects the sum to be formed from the older operand value, and the new value to be present in the register afterwards.

// File: rtl/cadd_pkg.sv
package cadd_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);
  localparam int CW   = 4;

  localparam logic [5:0] PRIM_OP = 6'b011111;
  localparam logic [8:0] EXT_OP  = 9'd138;

  typedef struct packed {
    logic           legal;
    logic [RAW-1:0] rd;
    logic [RAW-1:0] ra;
    logic [RAW-1:0] rb;
    logic           oe;
    logic           rc;
  } dec_t;

  typedef struct packed {
    logic [XLEN-1:0] sum;
    logic            cout;
    logic            ovf;
    logic            lt;
    logic            gt;
    logic            eq;
  } alu_t;
endpackage

// File: rtl/cadd_decode.sv
module cadd_decode
  import cadd_pkg::*;
(
  input  logic [31:0] instr_i,
  output dec_t        dec_o
);
  logic op_ok, xo_ok;

  always_comb begin
    op_ok       = (instr_i[31:26] == PRIM_OP);
    xo_ok       = (instr_i[9:1] == EXT_OP);
    dec_o.legal = op_ok & xo_ok;
    dec_o.rd    = instr_i[25:21];
    dec_o.ra    = instr_i[20:16];
    dec_o.rb    = instr_i[15:11];
    dec_o.oe    = instr_i[10];
    dec_o.rc    = instr_i[0];
  end
endmodule

// File: rtl/cadd_regfile.sv
module cadd_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_addr_i,
  input  logic [AW-1:0] rb_addr_i,
  output logic [W-1:0]  ra_data_o,
  output logic [W-1:0]  rb_data_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          dbg_we_i,
  input  logic [AW-1:0] dbg_waddr_i,
  input  logic [W-1:0]  dbg_wdata_i,
  input  logic [AW-1:0] dbg_raddr_i,
  output logic [W-1:0]  dbg_rdata_o
);
  logic [W-1:0] mem_q [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    // execute writeback has priority over debug write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[i] <= '0;
      else if (we_i && waddr_i == AW'(i))         mem_q[i] <= wdata_i;
      else if (dbg_we_i && dbg_waddr_i == AW'(i)) mem_q[i] <= dbg_wdata_i;
    end
  end

  assign ra_data_o   = mem_q[ra_addr_i];
  assign rb_data_o   = mem_q[rb_addr_i];
  assign dbg_rdata_o = mem_q[dbg_raddr_i];

  a_r10_exec_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && dbg_we_i && waddr_i == dbg_waddr_i) |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));

  a_r1_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/cadd_alu.sv
module cadd_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o,
  output logic         lt_o,
  output logic         gt_o,
  output logic         eq_o
);
  logic [W:0] full;

  always_comb begin
    full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    sum_o  = full[W-1:0];
    cout_o = full[W];
    // signed overflow: like-signed operands, result sign differs
    ovf_o  = (a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1]);
    eq_o   = (sum_o == '0);
    lt_o   = sum_o[W-1];
    gt_o   = !lt_o && !eq_o;
  end
endmodule

// File: rtl/cadd_flags.sv
module cadd_flags
  import cadd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic          oe_i,
  input  logic          rc_i,
  input  logic          cout_i,
  input  logic          ovf_i,
  input  logic          lt_i,
  input  logic          gt_i,
  input  logic          eq_i,
  output logic          ca_o,
  output logic          ov_o,
  output logic          so_o,
  output logic [CW-1:0] cond_o
);
  logic          ca_q, ov_q, so_q;
  logic [CW-1:0] cond_q;
  logic          so_nxt;

  assign so_nxt = so_q | (oe_i & ovf_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ca_q   <= 1'b0;
      ov_q   <= 1'b0;
      so_q   <= 1'b0;
      cond_q <= '0;
    end else if (upd_i) begin
      ca_q <= cout_i;
      if (oe_i) begin
        ov_q <= ovf_i;
        so_q <= so_nxt;
      end
      if (rc_i) cond_q <= {lt_i, gt_i, eq_i, so_nxt};
    end
  end

  assign ca_o   = ca_q;
  assign ov_o   = ov_q;
  assign so_o   = so_q;
  assign cond_o = cond_q;

  a_r4_ov_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !oe_i) |=> ($stable(ov_q) && $stable(so_q)));

  a_r5_so_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_q |=> so_q);

  a_r6_cond_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && rc_i) |=> ($onehot(cond_q[3:1]) && cond_q[0] == so_q));

  a_r7_cond_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_i && rc_i) |=> $stable(cond_q));

  a_r3_ca_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(ca_q));
endmodule

// File: rtl/cadd_unit.sv
module cadd_unit
  import cadd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic            dbg_we_i,
  input  logic [RAW-1:0]  dbg_waddr_i,
  input  logic [XLEN-1:0] dbg_wdata_i,
  input  logic [RAW-1:0]  dbg_raddr_i,
  output logic [XLEN-1:0] dbg_rdata_o,
  output logic            done_o,
  output logic            illegal_o,
  output logic            ca_o,
  output logic            ov_o,
  output logic            so_o,
  output logic [CW-1:0]   cond_o
);
  dec_t            dec;
  alu_t            alu;
  logic [XLEN-1:0] op_a, op_b;
  logic            exec;
  logic            done_q, ill_q;

  cadd_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  assign exec = valid_i & dec.legal;

  cadd_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ra_addr_i   (dec.ra),
    .rb_addr_i   (dec.rb),
    .ra_data_o   (op_a),
    .rb_data_o   (op_b),
    .we_i        (exec),
    .waddr_i     (dec.rd),
    .wdata_i     (alu.sum),
    .dbg_we_i    (dbg_we_i),
    .dbg_waddr_i (dbg_waddr_i),
    .dbg_wdata_i (dbg_wdata_i),
    .dbg_raddr_i (dbg_raddr_i),
    .dbg_rdata_o (dbg_rdata_o)
  );

  cadd_alu #(.W(XLEN)) u_alu (
    .a_i    (op_a),
    .b_i    (op_b),
    .cin_i  (ca_o),
    .sum_o  (alu.sum),
    .cout_o (alu.cout),
    .ovf_o  (alu.ovf),
    .lt_o   (alu.lt),
    .gt_o   (alu.gt),
    .eq_o   (alu.eq)
  );

  cadd_flags u_flg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (exec),
    .oe_i   (dec.oe),
    .rc_i   (dec.rc),
    .cout_i (alu.cout),
    .ovf_i  (alu.ovf),
    .lt_i   (alu.lt),
    .gt_i   (alu.gt),
    .eq_i   (alu.eq),
    .ca_o   (ca_o),
    .ov_o   (ov_o),
    .so_o   (so_o),
    .cond_o (cond_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      done_q <= valid_i;
      ill_q  <= valid_i & ~dec.legal;
    end
  end

  assign done_o    = done_q;
  assign illegal_o = ill_q;

  a_r8_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);

  a_r8_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);

  a_r2_illegal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dec.legal) |=> (illegal_o && $stable(ca_o) && $stable(ov_o)
                                 && $stable(so_o) && $stable(cond_o)));

  a_r2_illegal_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> done_o);
endmodule

// File: tb/sim_cadd_unit.sv
module sim_cadd_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        dbg_we_i = 1'b0;
  logic [4:0]  dbg_waddr_i = '0;
  logic [31:0] dbg_wdata_i = '0;
  logic [4:0]  dbg_raddr_i = '0;
  logic [31:0] dbg_rdata_o;
  logic        done_o, illegal_o, ca_o, ov_o, so_o;
  logic [3:0]  cond_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  cadd_unit u0 (.*);

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        ci;
    logic        oe;
    logic        rc;
    logic [31:0] sum;
    logic        co;
    logic        ov;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h00000005, 32'h00000007, 1'b0, 1'b1, 1'b1, 32'h0000000C, 1'b0, 1'b0},
    '{32'h00000005, 32'h00000007, 1'b1, 1'b0, 1'b1, 32'h0000000D, 1'b0, 1'b0},
    '{32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b1, 1'b1, 32'h00000000, 1'b1, 1'b0},
    '{32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 1'b0, 32'h00000000, 1'b1, 1'b0},
    '{32'h7FFFFFFF, 32'h00000000, 1'b1, 1'b1, 1'b1, 32'h80000000, 1'b0, 1'b1},
    '{32'h80000000, 32'h80000000, 1'b0, 1'b0, 1'b1, 32'h00000000, 1'b1, 1'b1},
    '{32'h80000000, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 32'h80000000, 1'b1, 1'b0},
    '{32'h12345678, 32'h11111111, 1'b0, 1'b1, 1'b1, 32'h23456789, 1'b0, 1'b0},
    '{32'hFFFFFFFE, 32'h00000000, 1'b1, 1'b0, 1'b1, 32'hFFFFFFFF, 1'b0, 1'b0}
  };

  function automatic logic [31:0] enc(input logic [4:0] rd, ra, rb, input logic oe, rc);
    return {6'b011111, rd, ra, rb, oe, 9'd138, rc};
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic dbg_wr(input logic [4:0] addr, input logic [31:0] data);
    dbg_we_i = 1'b1; dbg_waddr_i = addr; dbg_wdata_i = data;
    @(negedge clk_i);
    dbg_we_i = 1'b0;
  endtask

  task automatic issue(input logic [31:0] w);
    valid_i = 1'b1; instr_i = w;
    @(negedge clk_i);
    valid_i = 1'b0; instr_i = '0;
  endtask

  task automatic rd_reg(input logic [4:0] addr, output logic [31:0] v);
    dbg_raddr_i = addr;
    #0.5;
    v = dbg_rdata_o;
  endtask

  // r0 stays zero; r28/r29 preset so that r28+r29 always carries
  task automatic set_ca(input logic c);
    if (c) issue(enc(5'd27, 5'd28, 5'd29, 1'b0, 1'b0));
    else   issue(enc(5'd27, 5'd0, 5'd0, 1'b0, 1'b0));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v, lo, hi;
    logic m_ov, m_so;
    logic [3:0] m_cond;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 reset state
    rd_reg(5'd3, v);
    check("R9 reg", v, 32'h0);
    check("R9 flags", {26'h0, ca_o, ov_o, so_o, cond_o}, 32'h0);
    check("R9 pulses", {30'h0, done_o, illegal_o}, 32'h0);

    dbg_wr(5'd28, 32'hFFFFFFFF);
    dbg_wr(5'd29, 32'h00000001);

    // vector table: R1 R3 R4 R5 R6 R7
    m_ov = 1'b0; m_so = 1'b0; m_cond = 4'h0;
    for (int i = 0; i < NV; i++) begin
      dbg_wr(5'd1, VECS[i].a);
      dbg_wr(5'd2, VECS[i].b);
      set_ca(VECS[i].ci);
      check("R3 ca preset", {31'h0, ca_o}, {31'h0, VECS[i].ci});
      issue(enc(5'd3, 5'd1, 5'd2, VECS[i].oe, VECS[i].rc));
      if (VECS[i].oe) begin
        m_ov = VECS[i].ov;
        m_so = m_so | VECS[i].ov;
      end
      if (VECS[i].rc)
        m_cond = {VECS[i].sum[31], !VECS[i].sum[31] && VECS[i].sum != 0,
                  VECS[i].sum == 0, m_so};
      check("R8 done", {31'h0, done_o}, 32'h1);
      rd_reg(5'd3, v);
      check("R1 sum", v, VECS[i].sum);
      check("R3 carry", {31'h0, ca_o}, {31'h0, VECS[i].co});
      check("R4 ov", {31'h0, ov_o}, {31'h0, m_ov});
      check("R5 so", {31'h0, so_o}, {31'h0, m_so});
      check("R6 R7 cond", {28'h0, cond_o}, {28'h0, m_cond});
      @(negedge clk_i);
      check("R8 done single", {31'h0, done_o}, 32'h0);
    end

    // R5: SO stays set across a clean overflow-enabled add
    dbg_wr(5'd1, 32'h1);
    dbg_wr(5'd2, 32'h1);
    set_ca(1'b0);
    issue(enc(5'd4, 5'd1, 5'd2, 1'b1, 1'b1));
    check("R5 ov cleared", {31'h0, ov_o}, 32'h0);
    check("R5 so sticky", {31'h0, so_o}, 32'h1);
    check("R6 cond so copy", {28'h0, cond_o}, 32'h5);

    // R2 illegal encodings
    dbg_wr(5'd5, 32'hCAFEF00D);
    set_ca(1'b1);
    issue({6'b011110, 5'd5, 5'd1, 5'd2, 1'b1, 9'd138, 1'b1});
    check("R2 illegal op", {30'h0, done_o, illegal_o}, 32'h3);
    rd_reg(5'd5, v);
    check("R2 rd kept", v, 32'hCAFEF00D);
    check("R2 flags kept", {26'h0, ca_o, ov_o, so_o, cond_o}, {26'h0, 1'b1, 1'b0, 1'b1, 4'h5});
    issue({6'b011111, 5'd5, 5'd1, 5'd2, 1'b1, 9'd10, 1'b1});
    check("R2 illegal xo", {31'h0, illegal_o}, 32'h1);
    rd_reg(5'd5, v);
    check("R2 rd kept xo", v, 32'hCAFEF00D);
    @(negedge clk_i);
    check("R2 illegal single", {31'h0, illegal_o}, 32'h0);

    // R10 collision: debug and add write same register
    set_ca(1'b0);
    dbg_we_i = 1'b1; dbg_waddr_i = 5'd6; dbg_wdata_i = 32'hAAAA5555;
    issue(enc(5'd6, 5'd1, 5'd2, 1'b0, 1'b0));
    dbg_we_i = 1'b0;
    rd_reg(5'd6, v);
    check("R10 exec wins", v, 32'h2);
    // R10: debug write to a source in the add cycle is not seen by it
    dbg_we_i = 1'b1; dbg_waddr_i = 5'd1; dbg_wdata_i = 32'h100;
    issue(enc(5'd7, 5'd1, 5'd2, 1'b0, 1'b0));
    dbg_we_i = 1'b0;
    rd_reg(5'd7, v);
    check("R10 old operand", v, 32'h2);
    rd_reg(5'd1, v);
    check("R10 debug landed", v, 32'h100);

    // R11 64-bit chain: 0x00000001_FFFFFFFF + 0x00000002_00000001
    dbg_wr(5'd10, 32'hFFFFFFFF);
    dbg_wr(5'd11, 32'h00000001);
    dbg_wr(5'd12, 32'h00000001);
    dbg_wr(5'd13, 32'h00000002);
    set_ca(1'b0);
    issue(enc(5'd14, 5'd10, 5'd11, 1'b0, 1'b0));
    issue(enc(5'd15, 5'd12, 5'd13, 1'b0, 1'b0));
    rd_reg(5'd14, lo);
    rd_reg(5'd15, hi);
    check("R11 chain lo", lo, 32'h00000000);
    check("R11 chain hi", hi, 32'h00000004);

    // R9 reset mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd_reg(5'd15, v);
    check("R9 reg cleared", v, 32'h0);
    check("R9 flags cleared", {26'h0, ca_o, ov_o, so_o, cond_o}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule